// File: doc/BRIEF.md
# IDE Register Access Width Router

This block stands between a host register bus and the register file of one IDE drive. Each host access carries a window select, a byte offset, a byte count (1, 2 or 4) and a read/write flag. The block decides from the width and offset together whether the access reaches the drive. If it does, the block raises exactly one strobe toward the drive side. If it does not, a write is discarded and a read returns all ones over the access width.

There are two windows. The control window holds a single byte register at a fixed offset. Reading it yields the alternate status and writing it sets device control. The data window maps every byte offset onto a byte-wide task-file register. The data port is reached only by a halfword or word access at offset zero. Multi-byte values are little-endian: the byte at the lowest address sits in bits 7:0. The returned read value is registered and is valid one clock after the read request.

Top module: `ide_width_router`

## Requirements
- R1: A 1-byte read of the control window (`req_win`=1) at offset `CTL_OFF` (default 2) raises `drv_ctl_rd` alone and returns the drive's alternate status, zero-extended, in `rd_data`.
- R2: A 1-byte write of the control window at offset `CTL_OFF` raises `drv_ctl_wr` alone, and the device-control byte is carried on `drv_wdata[7:0]`.
- R3: Any other read of the control window raises no drive strobe. It returns all ones of the access width: 0x000000FF for size 1, 0x0000FFFF for size 2 and 0xFFFFFFFF for size 4.
- R4: Any other write of the control window raises no drive strobe.
- R5: A 1-byte access to the data window (`req_win`=0) at any offset raises `drv_byte_rd` or `drv_byte_wr` with `drv_byte_sel` equal to the offset. A read returns the selected register zero-extended.
- R6: A 2-byte access to the data window at offset 0 raises `drv_word_rd` or `drv_word_wr` with `drv_word_wide`=0. Only bits 15:0 take part, little-endian, and a read returns the upper 16 bits as zero.
- R7: A 4-byte access to the data window at offset 0 raises `drv_word_rd` or `drv_word_wr` with `drv_word_wide`=1 and moves all 32 bits.
- R8: A 2-byte or 4-byte access to the data window at a nonzero offset raises no strobe. A read of this kind returns all ones of its width, and a write of this kind changes no drive register.
- R9: `rd_valid` is 1 exactly in the cycle after a cycle in which a read request was presented, and 0 after writes and idle cycles.
- R10: While reset is held and after it is released, `rd_valid` and `rd_data` are 0 until the first read completes.
- R11: A request whose size is not 1, 2 or 4 is rejected in either window. A read of this kind returns 0xFFFFFFFF, and no strobe is raised.
- R12: At most one drive strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = data window, 1 = control window |
| req_off | input | OFF_W | Byte offset within the window |
| req_size | input | 3 | Byte count: 1, 2 or 4 |
| req_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Registered read value |
| rd_valid | output | 1 | Read value valid |
| drv_byte_rd | output | 1 | Task-file register read strobe |
| drv_byte_wr | output | 1 | Task-file register write strobe |
| drv_byte_sel | output | OFF_W | Task-file register index |
| drv_word_rd | output | 1 | Data port read strobe |
| drv_word_wr | output | 1 | Data port write strobe |
| drv_word_wide | output | 1 | Data port transfer is 32-bit |
| drv_ctl_rd | output | 1 | Alternate status read strobe |
| drv_ctl_wr | output | 1 | Device control write strobe |
| drv_wdata | output | 32 | Write data toward the drive |
| drv_byte_rdata | input | 8 | Selected task-file register value |
| drv_word_rdata | input | 32 | Data port value |
| drv_alt_status | input | 8 | Alternate status value |

## Verification
The bench builds the block with its defaults: `OFF_W`=3 and `CTL_OFF`=2. With these values all eight task-file offsets can be walked, and the accepted control offset sits between rejected neighbours on both sides. Offsets 2 and 4 give nonzero-offset halfword and word cases in the data window. A halfword write after a word write shows that only the low half of the data port moves.

// File: rtl/ide_rt_pkg.sv
package ide_rt_pkg;
  localparam int DW   = 32;
  localparam int SZ_W = 3;

  typedef enum logic [2:0] {
    RT_NONE,
    RT_TASK,
    RT_DATA16,
    RT_DATA32,
    RT_CTRL
  } route_e;

  function automatic logic [DW-1:0] ones_of(input logic [SZ_W-1:0] sz);
    case (sz)
      3'd1:    ones_of = 32'h0000_00FF;
      3'd2:    ones_of = 32'h0000_FFFF;
      default: ones_of = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ide_rt_decode.sv
module ide_rt_decode
  import ide_rt_pkg::*;
#(
  parameter int OFF_W   = 3,
  parameter int CTL_OFF = 2
) (
  input  logic             win,
  input  logic [OFF_W-1:0] off,
  input  logic [SZ_W-1:0]  size,
  output route_e           route
);
  localparam logic [OFF_W-1:0] CTL_AT = OFF_W'(CTL_OFF);

  always_comb begin
    route = RT_NONE;
    case (size)
      3'd1: route = win ? ((off == CTL_AT) ? RT_CTRL : RT_NONE) : RT_TASK;
      3'd2: if (!win && off == '0) route = RT_DATA16;
      3'd4: if (!win && off == '0) route = RT_DATA32;
      default: route = RT_NONE;
    endcase
  end
endmodule

// File: rtl/ide_rt_rdmux.sv
module ide_rt_rdmux
  import ide_rt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_req,
  input  route_e          route,
  input  logic [SZ_W-1:0] size,
  input  logic [7:0]      byte_in,
  input  logic [DW-1:0]   word_in,
  input  logic [7:0]      alt_in,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid
);
  logic [DW-1:0] sel_d;

  always_comb begin
    case (route)
      RT_TASK:   sel_d = {24'h0, byte_in};
      RT_CTRL:   sel_d = {24'h0, alt_in};
      RT_DATA16: sel_d = {16'h0, word_in[15:0]};
      RT_DATA32: sel_d = word_in;
      default:   sel_d = ones_of(size);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= sel_d;
    end
  end

  a_r9_valid_follows_read : assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  a_r9_no_spurious_valid : assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  a_r10_reset_clears : assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_data == '0));
endmodule

// File: rtl/ide_width_router.sv
module ide_width_router
  import ide_rt_pkg::*;
#(
  parameter int OFF_W   = 3,
  parameter int CTL_OFF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_win,
  input  logic [OFF_W-1:0] req_off,
  input  logic [2:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             drv_byte_rd,
  output logic             drv_byte_wr,
  output logic [OFF_W-1:0] drv_byte_sel,
  output logic             drv_word_rd,
  output logic             drv_word_wr,
  output logic             drv_word_wide,
  output logic             drv_ctl_rd,
  output logic             drv_ctl_wr,
  output logic [31:0]      drv_wdata,
  input  logic [7:0]       drv_byte_rdata,
  input  logic [31:0]      drv_word_rdata,
  input  logic [7:0]       drv_alt_status
);
  route_e route;
  logic   rd_req, wr_req;

  ide_rt_decode #(.OFF_W(OFF_W), .CTL_OFF(CTL_OFF)) dec_i (
    .win   (req_win),
    .off   (req_off),
    .size  (req_size),
    .route (route)
  );

  assign rd_req = req_valid && !req_write;
  assign wr_req = req_valid &&  req_write;

  assign drv_byte_rd   = rd_req && route == RT_TASK;
  assign drv_byte_wr   = wr_req && route == RT_TASK;
  assign drv_byte_sel  = req_off;
  assign drv_word_rd   = rd_req && (route == RT_DATA16 || route == RT_DATA32);
  assign drv_word_wr   = wr_req && (route == RT_DATA16 || route == RT_DATA32);
  assign drv_word_wide = route == RT_DATA32;
  assign drv_ctl_rd    = rd_req && route == RT_CTRL;
  assign drv_ctl_wr    = wr_req && route == RT_CTRL;
  assign drv_wdata     = req_wdata;

  ide_rt_rdmux mux_i (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .route    (route),
    .size     (req_size),
    .byte_in  (drv_byte_rdata),
    .word_in  (drv_word_rdata),
    .alt_in   (drv_alt_status),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  a_r12_single_strobe : assert property (@(posedge clk) disable iff (rst)
    $onehot0({drv_byte_rd, drv_byte_wr, drv_word_rd, drv_word_wr, drv_ctl_rd, drv_ctl_wr}));
  a_r4_ctl_write_dropped : assert property (@(posedge clk) disable iff (rst)
    (wr_req && req_win && (req_size != 3'd1 || req_off != OFF_W'(CTL_OFF)))
      |-> !(drv_byte_wr || drv_word_wr || drv_ctl_wr));
  a_r3_ctl_byte_ones : assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_win && req_size == 3'd1 && req_off != OFF_W'(CTL_OFF))
      |=> rd_data == 32'h0000_00FF);
  a_r8_unaligned_no_strobe : assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_win && req_size != 3'd1 && req_off != '0)
      |-> !(drv_word_rd || drv_word_wr || drv_byte_rd || drv_byte_wr));
  a_r11_bad_size_ones : assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_size != 3'd1 && req_size != 3'd2 && req_size != 3'd4)
      |=> rd_data == 32'hFFFF_FFFF);
endmodule

// File: tb/ide_width_router_tb.sv
module ide_width_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_win = 1'b0;
  logic [2:0]  req_off = '0, req_size = 3'd1;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        drv_byte_rd, drv_byte_wr, drv_word_rd, drv_word_wr, drv_word_wide;
  logic        drv_ctl_rd, drv_ctl_wr;
  logic [2:0]  drv_byte_sel;
  logic [31:0] drv_wdata;
  logic [7:0]  drv_byte_rdata, drv_alt_status;
  logic [31:0] drv_word_rdata;

  int vectors = 0, miscompares = 0;

  logic [7:0]  tf [8];
  logic [31:0] dport;
  logic [7:0]  devctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_width_router dut_i (.*);

  assign drv_byte_rdata = tf[drv_byte_sel];
  assign drv_word_rdata = dport;
  assign drv_alt_status = 8'h5A;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) tf[i] <= 8'(i * 17);
      dport  <= 32'h0;
      devctl <= 8'h0;
    end else begin
      if (drv_byte_wr) tf[drv_byte_sel] <= drv_wdata[7:0];
      if (drv_word_wr) begin
        if (drv_word_wide) dport <= drv_wdata;
        else dport[15:0] <= drv_wdata[15:0];
      end
      if (drv_ctl_wr) devctl <= drv_wdata[7:0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe code: [6]byte_rd [5]byte_wr [4]word_rd [3]word_wr [2]ctl_rd [1]ctl_wr [0]wide
  task automatic xfer(input bit w, input bit win, input logic [2:0] off, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output logic [6:0] strb,
                      output logic [2:0] sel, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_win = win; req_off = off; req_size = sz; req_wdata = wd;
    #1;
    strb = {drv_byte_rd, drv_byte_wr, drv_word_rd, drv_word_wr, drv_ctl_rd, drv_ctl_wr,
            drv_word_wide && (drv_word_rd || drv_word_wr)};
    sel = drv_byte_sel;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    rd  = rd_data;
    vld = rd_valid;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R10 rd_valid", 32'(rd_valid), 0);
    chk(rd_data == 32'h0, "R10 rd_data", rd_data, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] r; logic [6:0] s; logic [2:0] q; logic v;
    xfer(0, 1, 3'd2, 3'd1, 0, r, s, q, v);
    chk(s == 7'b0000100, "R1 strobe", 32'(s), 32'b0000100);
    chk(r == 32'h5A, "R1 data", r, 32'h5A);
    chk(v == 1'b1, "R9 valid after read", 32'(v), 1);
    xfer(1, 1, 3'd2, 3'd1, 32'h06, r, s, q, v);
    chk(s == 7'b0000010, "R2 strobe", 32'(s), 32'b0000010);
    chk(v == 1'b0, "R9 no valid after write", 32'(v), 0);
    chk(devctl == 8'h06, "R2 devctl", 32'(devctl), 32'h06);
    xfer(0, 1, 3'd0, 3'd1, 0, r, s, q, v);
    chk(r == 32'hFF && s == 0, "R3 byte off0", r, 32'hFF);
    xfer(0, 1, 3'd3, 3'd1, 0, r, s, q, v);
    chk(r == 32'hFF && s == 0, "R3 byte off3", r, 32'hFF);
    xfer(0, 1, 3'd2, 3'd2, 0, r, s, q, v);
    chk(r == 32'hFFFF && s == 0, "R3 half off2", r, 32'hFFFF);
    xfer(0, 1, 3'd2, 3'd4, 0, r, s, q, v);
    chk(r == 32'hFFFFFFFF && s == 0, "R3 word off2", r, 32'hFFFFFFFF);
    xfer(1, 1, 3'd0, 3'd1, 32'hAA, r, s, q, v);
    chk(s == 0, "R4 byte off0 write strobe", 32'(s), 0);
    xfer(1, 1, 3'd2, 3'd2, 32'hBB, r, s, q, v);
    chk(s == 0, "R4 half off2 write strobe", 32'(s), 0);
  endtask

  task automatic t_task;
    logic [31:0] r; logic [6:0] s; logic [2:0] q; logic v;
    for (int i = 0; i < 8; i++) begin
      xfer(1, 0, 3'(i), 3'd1, 32'hC0 + 32'(i), r, s, q, v);
      chk(s == 7'b0100000 && q == 3'(i), "R5 byte write strobe", {25'h0, s}, 32'b0100000);
    end
    for (int i = 0; i < 8; i++) begin
      xfer(0, 0, 3'(i), 3'd1, 0, r, s, q, v);
      chk(s == 7'b1000000 && q == 3'(i), "R5 byte read strobe", {25'h0, s}, 32'b1000000);
      chk(r == 32'hC0 + 32'(i), "R5 byte read data", r, 32'hC0 + 32'(i));
    end
  endtask

  task automatic t_data;
    logic [31:0] r; logic [6:0] s; logic [2:0] q; logic v;
    xfer(1, 0, 3'd0, 3'd4, 32'h11223344, r, s, q, v);
    chk(s == 7'b0001001, "R7 word write strobe", 32'(s), 32'b0001001);
    xfer(0, 0, 3'd0, 3'd4, 0, r, s, q, v);
    chk(s == 7'b0010001, "R7 word read strobe", 32'(s), 32'b0010001);
    chk(r == 32'h11223344, "R7 word read data", r, 32'h11223344);
    xfer(0, 0, 3'd0, 3'd2, 0, r, s, q, v);
    chk(s == 7'b0010000, "R6 half read strobe", 32'(s), 32'b0010000);
    chk(r == 32'h3344, "R6 half read data", r, 32'h3344);
    xfer(1, 0, 3'd0, 3'd2, 32'hFFFFBEEF, r, s, q, v);
    chk(s == 7'b0001000, "R6 half write strobe", 32'(s), 32'b0001000);
    xfer(0, 0, 3'd0, 3'd4, 0, r, s, q, v);
    chk(r == 32'h1122BEEF, "R6 half write low lane only", r, 32'h1122BEEF);
  endtask

  task automatic t_reject;
    logic [31:0] r; logic [6:0] s; logic [2:0] q; logic v;
    xfer(0, 0, 3'd2, 3'd2, 0, r, s, q, v);
    chk(r == 32'hFFFF && s == 0, "R8 half read off2", r, 32'hFFFF);
    xfer(0, 0, 3'd4, 3'd4, 0, r, s, q, v);
    chk(r == 32'hFFFFFFFF && s == 0, "R8 word read off4", r, 32'hFFFFFFFF);
    xfer(1, 0, 3'd2, 3'd2, 32'h0, r, s, q, v);
    chk(s == 0, "R8 half write off2 strobe", 32'(s), 0);
    xfer(1, 0, 3'd4, 3'd4, 32'h0, r, s, q, v);
    chk(s == 0, "R8 word write off4 strobe", 32'(s), 0);
    xfer(0, 0, 3'd2, 3'd1, 0, r, s, q, v);
    chk(r == 32'hC2, "R8 task reg unchanged", r, 32'hC2);
    xfer(0, 0, 3'd4, 3'd1, 0, r, s, q, v);
    chk(r == 32'hC4, "R8 task reg4 unchanged", r, 32'hC4);
    xfer(0, 0, 3'd0, 3'd4, 0, r, s, q, v);
    chk(r == 32'h1122BEEF, "R8 data port unchanged", r, 32'h1122BEEF);
  endtask

  task automatic t_badsize;
    logic [31:0] r; logic [6:0] s; logic [2:0] q; logic v;
    xfer(0, 0, 3'd0, 3'd3, 0, r, s, q, v);
    chk(r == 32'hFFFFFFFF && s == 0, "R11 size3 data read", r, 32'hFFFFFFFF);
    xfer(0, 1, 3'd2, 3'd0, 0, r, s, q, v);
    chk(r == 32'hFFFFFFFF && s == 0, "R11 size0 ctrl read", r, 32'hFFFFFFFF);
    xfer(1, 0, 3'd0, 3'd7, 32'h0, r, s, q, v);
    chk(s == 0, "R11 size7 write strobe", 32'(s), 0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R9 idle no valid", 32'(rd_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_task();
    t_data();
    t_reject();
    t_badsize();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule